// File: doc/BRIEF.md
# Synthesizer Divider Configuration Controller

This block keeps the divider settings of a clock synthesizer: a 10-bit feedback count, a 3-bit primary output ratio code, one secondary ratio bit and one prescale bit. Two sources can supply these settings. The first is a 15-pin parallel input. The second is a pair of shadow registers written over a byte-wide register port. A mode input chooses the source. In parallel mode the pins drive the active latches on every clock, and the shadow registers follow the active setting. In serial mode the pins are ignored. The shadow registers then accept writes, and a command register moves settings between the shadow and active copies or steps the feedback count up or down by one.

The active latches feed the synthesizer's dividers directly. The two shadow read values are presented so that a bus front end can return them. The low bit of the upper read value shows the lock flag live. A one-cycle pulse marks every change of the feedback count or the prescale bit, so that downstream logic can restart its lock tracking.

Top module: `dcfg_ctrl`

## Requirements
- R1: While `master_rst` is high at a clock edge, the active and shadow settings return to M=500, ratio code 3'b010, secondary bit 0, prescale bit 1. `rd_lo` then reads 8'hF4, `rd_hi[7:1]` reads 7'b0101001, and `cfg_changed` is 0.
- R2: At the first edge on which `master_rst` is low after a reset, both the active and shadow settings take the pin values, whatever the level of `mode_ser`.
- R3: While `mode_ser` is 0, each edge copies the pins into the active latches, so a pin change appears one cycle later.
- R4: While `mode_ser` is 0, the shadow settings equal the active settings, and register writes, including commands, have no effect.
- R5: `rd_lo` is shadow M[7:0]. `rd_hi` from bit 7 down to bit 0 is shadow M9, M8, the three ratio-code bits (MSB first), the secondary bit, the prescale bit and the lock flag.
- R6: In serial mode, a write to address 8'h00 replaces shadow M[7:0]. A write to 8'h01 replaces shadow bits 7..1 of the upper value, and data bit 0 is dropped. A write to any other address except 8'hF0 changes nothing. Writes never alter the active latches directly.
- R7: `rd_hi[0]` follows `lock_in` combinationally, and nothing written to it is kept.
- R8: In serial mode, writing 8'h01 to address 8'hF0 adds 1 to the active M, and writing 8'h02 subtracts 1. Both wrap modulo 1024 and leave the shadow settings and the other active fields alone.
- R9: In serial mode, writing 8'h04 to address 8'hF0 copies the shadow settings into the active latches, and writing 8'h08 copies the active settings into the shadow registers. Any other data value written to 8'hF0 is ignored.
- R10: When `mode_ser` rises, both copies keep their values and later pin changes are ignored. When it falls, the pins take over at the next edge.
- R11: `cfg_changed` is 1 for exactly the cycle after an edge that changed the active M or prescale bit. A change of the ratio code or the secondary bit alone does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| master_rst | input | 1 | Synchronous active-high master reset; its release loads the pins |
| mode_ser | input | 1 | 0 = parallel pins drive the settings, 1 = register port drives them |
| pin_m | input | 10 | Parallel feedback count |
| pin_na | input | 3 | Parallel primary ratio code |
| pin_nb | input | 1 | Parallel secondary ratio bit |
| pin_p | input | 1 | Parallel prescale bit |
| lock_in | input | 1 | Lock flag from the loop |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| act_m | output | 10 | Active feedback count |
| act_na | output | 3 | Active primary ratio code |
| act_nb | output | 1 | Active secondary ratio bit |
| act_p | output | 1 | Active prescale bit |
| rd_lo | output | 8 | Low shadow read value |
| rd_hi | output | 8 | High shadow read value with the live lock bit |
| cfg_changed | output | 1 | One-cycle pulse after M or the prescale bit changes |

## Verification
A corrupted active latch shows on the `act_*` outputs on the cycle right after the edge that wrote it. In parallel mode a corrupted shadow copy shows on `rd_lo`/`rd_hi` within one cycle. In serial mode the shadow copy and the active setting separate on purpose, so a wrong shadow value is visible at the read ports but affects the active outputs only after a LOAD. A wrong feedback step appears on `act_m` together with a missing or extra `cfg_changed` pulse in the same cycle. The full parallel sweep and the full wrap in both directions expose every bit position and every carry or borrow.

// File: rtl/dcfg_pkg.sv
package dcfg_pkg;

    localparam int M_W   = 10;
    localparam int NA_W  = 3;
    localparam int REG_W = 8;
    localparam int CFG_W = M_W + NA_W + 2;

    typedef struct packed {
        logic [M_W-1:0]  m;
        logic [NA_W-1:0] na;
        logic            nb;
        logic            p;
    } div_cfg_t;

    localparam div_cfg_t CFG_DEFAULT = '{m: 10'd500, na: 3'b010, nb: 1'b0, p: 1'b1};

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_WR_LO,
        ACT_WR_HI,
        ACT_INC,
        ACT_DEC,
        ACT_LOAD,
        ACT_GET
    } act_e;

    localparam logic [REG_W-1:0] OP_INC  = 8'h01;
    localparam logic [REG_W-1:0] OP_DEC  = 8'h02;
    localparam logic [REG_W-1:0] OP_LOAD = 8'h04;
    localparam logic [REG_W-1:0] OP_GET  = 8'h08;

    function automatic logic [REG_W-1:0] view_lo(div_cfg_t c);
        return c.m[7:0];
    endfunction

    function automatic logic [REG_W-1:0] view_hi(div_cfg_t c, logic lock);
        return {c.m[9:8], c.na, c.nb, c.p, lock};
    endfunction

    function automatic div_cfg_t merge_lo(div_cfg_t c, logic [REG_W-1:0] d);
        div_cfg_t r;
        r        = c;
        r.m[7:0] = d;
        return r;
    endfunction

    function automatic div_cfg_t merge_hi(div_cfg_t c, logic [REG_W-1:0] d);
        div_cfg_t r;
        r        = c;
        r.m[9:8] = d[7:6];
        r.na     = d[5:3];
        r.nb     = d[2];
        r.p      = d[1];
        return r;
    endfunction

endpackage

// File: rtl/dcfg_wr_decode.sv
module dcfg_wr_decode
    import dcfg_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] LO_ADDR  = 8'h00,
    parameter logic [ADDR_W-1:0] HI_ADDR  = 8'h01,
    parameter logic [ADDR_W-1:0] CMD_ADDR = 8'hF0
) (
    input  logic              serial_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output act_e              action
);

    always_comb begin
        action = ACT_NONE;
        if (serial_en && wr_en) begin
            if (wr_addr == LO_ADDR) begin
                action = ACT_WR_LO;
            end else if (wr_addr == HI_ADDR) begin
                action = ACT_WR_HI;
            end else if (wr_addr == CMD_ADDR) begin
                unique case (wr_data)
                    OP_INC:  action = ACT_INC;
                    OP_DEC:  action = ACT_DEC;
                    OP_LOAD: action = ACT_LOAD;
                    OP_GET:  action = ACT_GET;
                    default: action = ACT_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/dcfg_active_bank.sv
module dcfg_active_bank
    import dcfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     take_pins,
    input  div_cfg_t pin_cfg,
    input  act_e     action,
    input  div_cfg_t shadow_cfg,
    output div_cfg_t active_cfg,
    output logic     changed
);

    div_cfg_t cur_q;
    div_cfg_t nxt;
    logic     chg_q;

    always_comb begin
        nxt = cur_q;
        if (take_pins) begin
            nxt = pin_cfg;
        end else begin
            case (action)
                ACT_INC:  nxt.m = cur_q.m + M_W'(1);
                ACT_DEC:  nxt.m = cur_q.m - M_W'(1);
                ACT_LOAD: nxt   = shadow_cfg;
                default:  nxt   = cur_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= CFG_DEFAULT;
            chg_q <= 1'b0;
        end else begin
            cur_q <= nxt;
            chg_q <= (nxt.m != cur_q.m) || (nxt.p != cur_q.p);
        end
    end

    assign active_cfg = cur_q;
    assign changed    = chg_q;

endmodule

// File: rtl/dcfg_shadow_bank.sv
module dcfg_shadow_bank
    import dcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take_pins,
    input  div_cfg_t         pin_cfg,
    input  act_e             action,
    input  logic [REG_W-1:0] wr_data,
    input  div_cfg_t         active_cfg,
    output div_cfg_t         shadow_cfg
);

    div_cfg_t sh_q;
    div_cfg_t sh_nxt;

    always_comb begin
        sh_nxt = sh_q;
        if (take_pins) begin
            sh_nxt = pin_cfg;
        end else begin
            case (action)
                ACT_WR_LO: sh_nxt = merge_lo(sh_q, wr_data);
                ACT_WR_HI: sh_nxt = merge_hi(sh_q, wr_data);
                ACT_GET:   sh_nxt = active_cfg;
                default:   sh_nxt = sh_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= CFG_DEFAULT;
        end else begin
            sh_q <= sh_nxt;
        end
    end

    assign shadow_cfg = sh_q;

endmodule

// File: rtl/dcfg_ctrl.sv
module dcfg_ctrl
    import dcfg_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] LO_ADDR  = 8'h00,
    parameter logic [ADDR_W-1:0] HI_ADDR  = 8'h01,
    parameter logic [ADDR_W-1:0] CMD_ADDR = 8'hF0
) (
    input  logic              clk,
    input  logic              master_rst,
    input  logic              mode_ser,
    input  logic [9:0]        pin_m,
    input  logic [2:0]        pin_na,
    input  logic              pin_nb,
    input  logic              pin_p,
    input  logic              lock_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [9:0]        act_m,
    output logic [2:0]        act_na,
    output logic              act_nb,
    output logic              act_p,
    output logic [7:0]        rd_lo,
    output logic [7:0]        rd_hi,
    output logic              cfg_changed
);

    logic     rst_seen_q;
    logic     startup;
    logic     take_pins;
    div_cfg_t pin_cfg;
    div_cfg_t active_cfg;
    div_cfg_t shadow_cfg;
    act_e     action;

    always_ff @(posedge clk) begin
        rst_seen_q <= master_rst;
    end

    assign startup   = rst_seen_q && !master_rst;
    assign take_pins = startup || !mode_ser;
    assign pin_cfg   = '{m: pin_m, na: pin_na, nb: pin_nb, p: pin_p};

    dcfg_wr_decode #(
        .ADDR_W   (ADDR_W),
        .LO_ADDR  (LO_ADDR),
        .HI_ADDR  (HI_ADDR),
        .CMD_ADDR (CMD_ADDR)
    ) dec_i (
        .serial_en (mode_ser),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .action    (action)
    );

    dcfg_active_bank act_i (
        .clk        (clk),
        .rst        (master_rst),
        .take_pins  (take_pins),
        .pin_cfg    (pin_cfg),
        .action     (action),
        .shadow_cfg (shadow_cfg),
        .active_cfg (active_cfg),
        .changed    (cfg_changed)
    );

    dcfg_shadow_bank sh_i (
        .clk        (clk),
        .rst        (master_rst),
        .take_pins  (take_pins),
        .pin_cfg    (pin_cfg),
        .action     (action),
        .wr_data    (wr_data),
        .active_cfg (active_cfg),
        .shadow_cfg (shadow_cfg)
    );

    assign act_m  = active_cfg.m;
    assign act_na = active_cfg.na;
    assign act_nb = active_cfg.nb;
    assign act_p  = active_cfg.p;
    assign rd_lo  = view_lo(shadow_cfg);
    assign rd_hi  = view_hi(shadow_cfg, lock_in);

endmodule

// File: rtl/dcfg_ctrl_chk.sv
module dcfg_ctrl_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CMD_ADDR = 8'hF0
) (
    input logic              clk,
    input logic              master_rst,
    input logic              mode_ser,
    input logic [9:0]        pin_m,
    input logic [2:0]        pin_na,
    input logic              pin_nb,
    input logic              pin_p,
    input logic              lock_in,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic [9:0]        act_m,
    input logic [2:0]        act_na,
    input logic              act_nb,
    input logic              act_p,
    input logic [7:0]        rd_lo,
    input logic [7:0]        rd_hi,
    input logic              cfg_changed
);

    logic [1:0] age_q = 2'd0;

    always_ff @(posedge clk) begin
        if (master_rst) begin
            age_q <= 2'd1;
        end else if (age_q != 2'd0 && age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    AST_RESET_DEFAULT: assert property (@(posedge clk)
        master_rst |=> (act_m == 10'd500 && act_na == 3'b010 && !act_nb && act_p
                        && rd_lo == 8'hF4 && rd_hi[7:1] == 7'b0101001 && !cfg_changed)); // R1

    AST_STARTUP_LOAD: assert property (@(posedge clk) disable iff (master_rst)
        $past(master_rst) |=> {act_m, act_na, act_nb, act_p} == $past({pin_m, pin_na, pin_nb, pin_p})); // R2

    AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (master_rst)
        !mode_ser |=> {act_m, act_na, act_nb, act_p} == $past({pin_m, pin_na, pin_nb, pin_p})); // R3

    AST_PAR_MIRROR: assert property (@(posedge clk) disable iff (master_rst)
        !mode_ser |=> (rd_lo == act_m[7:0] && rd_hi[7:1] == {act_m[9:8], act_na, act_nb, act_p})); // R4

    AST_LOCK_LIVE: assert property (@(posedge clk) disable iff (master_rst)
        rd_hi[0] == lock_in); // R7

    AST_INC_STEP: assert property (@(posedge clk) disable iff (master_rst)
        (mode_ser && wr_en && wr_addr == CMD_ADDR && wr_data == 8'h01 && !$past(master_rst))
        |=> (act_m == $past(act_m) + 10'd1 && $stable(rd_lo) && $stable(rd_hi[7:1]))); // R8

    AST_SER_HOLD: assert property (@(posedge clk) disable iff (master_rst)
        (mode_ser && !wr_en && !$past(master_rst))
        |=> ($stable({act_m, act_na, act_nb, act_p}) && $stable(rd_lo) && $stable(rd_hi[7:1]))); // R10

    AST_CHG_PULSE: assert property (@(posedge clk) disable iff (master_rst)
        (age_q >= 2'd2) |-> cfg_changed == ((act_m != $past(act_m)) || (act_p != $past(act_p)))); // R11

endmodule

bind dcfg_ctrl dcfg_ctrl_chk #(.ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR)) chk_i (
    .clk         (clk),
    .master_rst  (master_rst),
    .mode_ser    (mode_ser),
    .pin_m       (pin_m),
    .pin_na      (pin_na),
    .pin_nb      (pin_nb),
    .pin_p       (pin_p),
    .lock_in     (lock_in),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .act_m       (act_m),
    .act_na      (act_na),
    .act_nb      (act_nb),
    .act_p       (act_p),
    .rd_lo       (rd_lo),
    .rd_hi       (rd_hi),
    .cfg_changed (cfg_changed)
);

// File: tb/dcfg_ctrl_tb_top.sv
module dcfg_ctrl_tb_top;
    import dcfg_pkg::*;

    logic       clk = 1'b0;
    logic       master_rst = 1'b1;
    logic       mode_ser = 1'b1;
    logic [9:0] pin_m = 10'h3FF;
    logic [2:0] pin_na = 3'b111;
    logic       pin_nb = 1'b1;
    logic       pin_p = 1'b0;
    logic       lock_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [9:0] act_m;
    logic [2:0] act_na;
    logic       act_nb;
    logic       act_p;
    logic [7:0] rd_lo;
    logic [7:0] rd_hi;
    logic       cfg_changed;

    int errors = 0;
    int checks = 0;

    div_cfg_t e_act, e_sh;
    logic     e_chg = 1'b0;
    logic     e_rst_prev = 1'b1;
    localparam div_cfg_t TB_DEF = '{m: 10'd500, na: 3'b010, nb: 1'b0, p: 1'b1};

    always #5 clk = ~clk;

    dcfg_ctrl dut_i (
        .clk(clk), .master_rst(master_rst), .mode_ser(mode_ser),
        .pin_m(pin_m), .pin_na(pin_na), .pin_nb(pin_nb), .pin_p(pin_p),
        .lock_in(lock_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .act_m(act_m), .act_na(act_na), .act_nb(act_nb), .act_p(act_p),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .cfg_changed(cfg_changed)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic tick(input string tag);
        div_cfg_t prev;
        div_cfg_t pins;
        prev = e_act;
        pins = '{m: pin_m, na: pin_na, nb: pin_nb, p: pin_p};
        if (master_rst) begin
            e_act = TB_DEF;
            e_sh  = TB_DEF;
            e_chg = 1'b0;
        end else begin
            if (e_rst_prev || !mode_ser) begin
                e_act = pins;
                e_sh  = pins;
            end else if (wr_en) begin
                if (wr_addr == 8'h00) e_sh.m[7:0] = wr_data;
                else if (wr_addr == 8'h01) {e_sh.m[9:8], e_sh.na, e_sh.nb, e_sh.p} = wr_data[7:1];
                else if (wr_addr == 8'hF0) begin
                    case (wr_data)
                        8'h01: e_act.m = e_act.m + 10'd1;
                        8'h02: e_act.m = e_act.m - 10'd1;
                        8'h04: e_act = e_sh;
                        8'h08: e_sh = e_act;
                        default: ;
                    endcase
                end
            end
            e_chg = (e_act.m != prev.m) || (e_act.p != prev.p);
        end
        e_rst_prev = master_rst;
        @(posedge clk);
        #1;
        chk(tag, "act_m", 32'(act_m), 32'(e_act.m));
        chk(tag, "act_na", 32'(act_na), 32'(e_act.na));
        chk(tag, "act_nb", 32'(act_nb), 32'(e_act.nb));
        chk(tag, "act_p", 32'(act_p), 32'(e_act.p));
        chk(tag, "rd_lo", 32'(rd_lo), 32'(e_sh.m[7:0]));
        chk(tag, "rd_hi", 32'(rd_hi), 32'({e_sh.m[9:8], e_sh.na, e_sh.nb, e_sh.p, lock_in}));
        chk(tag, "cfg_changed", 32'(cfg_changed), 32'(e_chg));
    endtask

    task automatic set_pins(input logic [9:0] m, input logic [2:0] na, input logic nb, input logic p);
        pin_m = m; pin_na = na; pin_nb = nb; pin_p = p;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(tag);
        wr_en = 1'b0;
    endtask

    initial begin
        #1;
        // R1: reset state with hostile pin values
        tick("R1"); tick("R1"); tick("R1");
        chk("R1", "rd_lo literal", 32'(rd_lo), 32'h0F4);
        chk("R1", "rd_hi literal", 32'(rd_hi[7:1]), 32'b0101001);

        // R2: release in serial mode loads the pins into both copies
        set_pins(10'd137, 3'b100, 1'b1, 1'b0);
        master_rst = 1'b0;
        tick("R2");
        // R10: serial mode ignores pin changes
        set_pins(10'd725, 3'b001, 1'b0, 1'b1);
        tick("R10"); tick("R10");

        // R7: lock bit follows the flag without a clock
        lock_in = 1'b1; #1;
        chk("R7", "lock high", 32'(rd_hi[0]), 32'd1);
        lock_in = 1'b0; #1;
        chk("R7", "lock low", 32'(rd_hi[0]), 32'd0);
        lock_in = 1'b1;
        wr(8'h01, 8'h00, "R7");
        chk("R7", "write ignored", 32'(rd_hi[0]), 32'd1);

        // R6 R5: shadow writes, bit 0 dropped, other addresses ignored
        wr(8'h00, 8'hA5, "R6");
        wr(8'h01, 8'hB3, "R6 R5");
        wr(8'h05, 8'h77, "R6");
        wr(8'hF1, 8'h04, "R6");

        // R9: LOAD, stray opcode, GET
        wr(8'hF0, 8'h04, "R9");
        wr(8'hF0, 8'h03, "R9");
        wr(8'hF0, 8'h0C, "R9");
        wr(8'h00, 8'h11, "R9");
        wr(8'h01, 8'h4C, "R9");
        wr(8'hF0, 8'h08, "R9");

        // R8: full wrap upward then downward
        for (int i = 0; i < 1030; i++) wr(8'hF0, 8'h01, "R8 R11");
        for (int i = 0; i < 1030; i++) wr(8'hF0, 8'h02, "R8 R11");
        wr(8'hF0, 8'h04, "R9");

        // R10: falling mode takes the pins at the next edge
        set_pins(10'd300, 3'b011, 1'b1, 1'b0);
        mode_ser = 1'b0;
        tick("R10");

        // R3 R4 R5 R11: every pin pattern in parallel mode, writes mixed in
        for (int i = 0; i < 32768; i++) begin
            {pin_m, pin_na, pin_nb, pin_p} = i[14:0];
            wr_en   = (i % 5 == 0);
            wr_addr = (i % 3 == 0) ? 8'h00 : ((i % 3 == 1) ? 8'h01 : 8'hF0);
            wr_data = i[7:0] ^ 8'h5A;
            lock_in = i[3];
            tick("R3 R4 R5 R11");
        end
        wr_en = 1'b0;

        // R11: ratio-only change gives no pulse
        set_pins(10'd400, 3'b000, 1'b0, 1'b1); tick("R11");
        set_pins(10'd400, 3'b101, 1'b1, 1'b1); tick("R11");

        // R10: rising mode keeps values while pins move
        mode_ser = 1'b1;
        set_pins(10'd9, 3'b110, 1'b0, 1'b0);
        tick("R10"); tick("R10");

        // R1 R2: reset again, release in parallel mode
        master_rst = 1'b1; tick("R1"); tick("R1");
        mode_ser = 1'b0;
        set_pins(10'd612, 3'b001, 1'b0, 1'b0);
        master_rst = 1'b0; tick("R2"); tick("R3");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule